// File: doc/BRIEF.md
# Two-Channel Bit Interleaving Multiplexer

This block folds two serial bit streams, a voice channel and a conditioned order-wire channel, into one composite stream that runs at twice the rate of a slow select clock. The select clock is sampled in the system clock domain. While it is high the voice bit is chosen, and while it is low the order-wire bit is chosen. The voice bit first passes through an exclusive-OR conditioning stage. A control input on that stage can invert the voice data.

Both edges of the select clock are turned into one-cycle capture ticks. Each tick comes from comparing the synchronised select level with a copy of it delayed by one register. On each tick the merged bit is stored in a retiming register. The stored bit leaves the block through an output enable gate. With a 16 kHz select clock the composite stream carries 32 kb/s, one voice bit followed by one order-wire bit in every select period.

Top module: `bit_interleave_mux`

## Requirements
- R1: While the synchronised select level is 1, the capture takes the conditioned voice bit. While it is 0, the capture takes the order-wire bit.
- R2: The conditioned voice bit equals voice_i XOR voice_ctl_i. With voice_ctl_i = 1 the voice data reaches the output inverted.
- R3: Every rising edge and every falling edge of the select level produces exactly one capture, so the composite stream carries two bits per select period.
- R4: Between select edges the retimed bit holds, whatever the data and control inputs do.
- R5: A select edge applied before clock edge k changes comp_o after clock edge k+SYNC_STAGES and not earlier. SYNC_STAGES is the depth of the select synchroniser (default 2).
- R6: While out_en_i is 0, comp_o is 0. The retimed bit is kept and reappears in the same cycle that out_en_i returns to 1.
- R7: During and straight after an active-low reset, comp_o is 0 and no capture is pending.
- R8: A rising select edge followed by a falling one yields the voice bit and then the order-wire bit, so the output stream interleaves the two channels in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| sel_clk_i | input | 1 | Slow select clock (for example 16 kHz), asynchronous to clk |
| voice_i | input | 1 | Voice channel data bit |
| voice_ctl_i | input | 1 | Conditioning control; 1 inverts the voice bit |
| owire_i | input | 1 | Conditioned order-wire data bit |
| out_en_i | input | 1 | Output enable; 0 forces comp_o low |
| comp_o | output | 1 | Composite interleaved serial bit |

## Verification
With the default SYNC_STAGES of 2, a select edge driven between clock edges is captured at the third rising edge after it. The enable gate acts in the same cycle. The bench therefore holds each half-period for four cycles and samples on the falling clock edge at the end of each half. It also samples once just before the capture edge and once just after it, to pin the latency exactly. Enable checks sample one time unit after out_en_i is driven, because the gate is combinational.

// File: rtl/bim_pkg.sv
package bim_pkg;
   // which channel the current half of the select clock belongs to
   typedef enum logic {
      SRC_ORDER = 1'b0,
      SRC_VOICE = 1'b1
   } bim_src_e;

   // largest synchroniser depth the block accepts
   localparam int unsigned BIM_MAX_SYNC = 3;
endpackage

// File: rtl/bim_edge_tick.sv
module bim_edge_tick #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_raw_i,
   output logic sel_s_o,
   output logic sel_dly_o,
   output logic tick_o
);
   import bim_pkg::*;

   if (SYNC_STAGES > BIM_MAX_SYNC) begin : g_bad_depth
      $error("bim_edge_tick: SYNC_STAGES exceeds BIM_MAX_SYNC");
   end

   if (SYNC_STAGES == 0) begin : g_bypass
      assign sel_s_o = sel_raw_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] stg_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stg_q <= '0;
         end else begin
            stg_q[0] <= sel_raw_i;
            for (int i = 1; i < int'(SYNC_STAGES); i++) begin
               stg_q[i] <= stg_q[i-1];
            end
         end
      end
      assign sel_s_o = stg_q[SYNC_STAGES-1];
   end

   // one-register delay line; XOR with it marks both edges
   always_ff @(posedge clk) begin
      if (!rst_n) sel_dly_o <= 1'b0;
      else        sel_dly_o <= sel_s_o;
   end

   assign tick_o = sel_s_o ^ sel_dly_o;
endmodule

// File: rtl/bim_merge.sv
module bim_merge (
   input  bim_pkg::bim_src_e phase_i,
   input  logic              voice_i,
   input  logic              voice_ctl_i,
   input  logic              owire_i,
   output logic              merged_o
);
   import bim_pkg::*;

   logic voice_c;
   logic gate_v;
   logic gate_o;

   assign voice_c  = voice_i ^ voice_ctl_i;
   assign gate_v   = voice_c & (phase_i == SRC_VOICE);
   assign gate_o   = owire_i & (phase_i == SRC_ORDER);
   assign merged_o = gate_v | gate_o;
endmodule

// File: rtl/bim_retime.sv
module bim_retime (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic d_i,
   input  logic en_i,
   output logic q_o
);
   logic hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      hold_q <= 1'b0;
      else if (tick_i) hold_q <= d_i;
   end

   assign q_o = en_i & hold_q;
endmodule

// File: rtl/bit_interleave_mux.sv
module bit_interleave_mux #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_clk_i,
   input  logic voice_i,
   input  logic voice_ctl_i,
   input  logic owire_i,
   input  logic out_en_i,
   output logic comp_o
);
   import bim_pkg::*;

   logic     sel_s;
   logic     sel_dly;
   logic     tick;
   logic     merged;
   bim_src_e phase;

   bim_edge_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_raw_i (sel_clk_i),
      .sel_s_o   (sel_s),
      .sel_dly_o (sel_dly),
      .tick_o    (tick)
   );

   assign phase = bim_src_e'(sel_s);

   bim_merge u_merge (
      .phase_i     (phase),
      .voice_i     (voice_i),
      .voice_ctl_i (voice_ctl_i),
      .owire_i     (owire_i),
      .merged_o    (merged)
   );

   bim_retime u_rt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick),
      .d_i    (merged),
      .en_i   (out_en_i),
      .q_o    (comp_o)
   );
endmodule

// File: rtl/bim_chk.sv
module bim_chk (
   input logic clk,
   input logic rst_n,
   input logic sel_s,
   input logic sel_dly,
   input logic voice_i,
   input logic voice_ctl_i,
   input logic owire_i,
   input logic out_en_i,
   input logic comp_o
);
   // R1 R2 R3
   property p_capture;
      @(posedge clk) disable iff (!rst_n)
         ($past(sel_s) != $past(sel_dly)) && out_en_i |->
            comp_o == ($past(sel_s) ? ($past(voice_i) ^ $past(voice_ctl_i)) : $past(owire_i));
   endproperty
   capture_chk: assert property (p_capture);

   // R4
   property p_hold;
      @(posedge clk) disable iff (!rst_n)
         ($past(sel_s) == $past(sel_dly)) && out_en_i && $past(out_en_i) |-> $stable(comp_o);
   endproperty
   hold_chk: assert property (p_hold);

   // R6
   property p_gate;
      @(posedge clk) disable iff (!rst_n) !out_en_i |-> !comp_o;
   endproperty
   gate_chk: assert property (p_gate);

   // R7
   property p_reset;
      @(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> !comp_o;
   endproperty
   reset_chk: assert property (p_reset);
endmodule

bind bit_interleave_mux bim_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sel_s       (sel_s),
   .sel_dly     (sel_dly),
   .voice_i     (voice_i),
   .voice_ctl_i (voice_ctl_i),
   .owire_i     (owire_i),
   .out_en_i    (out_en_i),
   .comp_o      (comp_o)
);

// File: tb/bit_interleave_mux_test.sv
module bit_interleave_mux_test;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 2;
   localparam int HALF       = 4;
   localparam int NVEC       = 16;

   // {sel, voice, ctl, owire, en, expected}
   localparam logic [5:0] VEC [NVEC] = '{
      6'b1_1_0_0_1_1, 6'b0_1_0_0_1_0, 6'b1_0_0_1_1_0, 6'b0_0_0_1_1_1,
      6'b1_1_1_0_1_0, 6'b0_0_1_1_1_1, 6'b1_0_1_0_1_1, 6'b0_1_1_0_1_0,
      6'b1_1_0_1_0_0, 6'b0_0_0_1_0_0, 6'b1_1_0_1_1_1, 6'b0_1_1_0_1_0,
      6'b1_0_0_0_1_0, 6'b0_0_0_0_1_0, 6'b1_1_0_0_1_1, 6'b0_1_1_1_1_1
   };

   logic clk = 1'b0;
   logic rst_n, sel, voice, ctl, owire, en;
   logic comp;
   int   nvec = 0;
   int   nmiss = 0;
   bit   done = 1'b0;

   bit_interleave_mux #(.SYNC_STAGES(SYNC)) uut (
      .clk (clk), .rst_n (rst_n), .sel_clk_i (sel), .voice_i (voice),
      .voice_ctl_i (ctl), .owire_i (owire), .out_en_i (en), .comp_o (comp)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic act, input logic exp);
      nvec++;
      if (act !== exp) begin
         nmiss++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic apply(input logic s, input logic v, input logic c,
                        input logic o, input logic e);
      @(negedge clk);
      sel = s; voice = v; ctl = c; owire = o; en = e;
      repeat (HALF) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         nmiss++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nmiss);
         $finish;
      end
   end

   initial begin
      logic [7:0]  vb, ob;
      logic [15:0] got, want;
      rst_n = 1'b0; sel = 1'b0; voice = 1'b1; ctl = 1'b0; owire = 1'b1; en = 1'b1;
      repeat (3) @(negedge clk);
      // R7: output low during reset
      chk("R7 during reset", comp, 1'b0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R7: still low after reset with no select edge
      chk("R7 after reset", comp, 1'b0);

      // table: R1 R2 R3 R6
      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
         if (!VEC[i][1])     chk($sformatf("R6 vec %0d", i), comp, VEC[i][0]);
         else if (VEC[i][3]) chk($sformatf("R2 vec %0d", i), comp, VEC[i][0]);
         else                chk($sformatf("R1 R3 vec %0d", i), comp, VEC[i][0]);
      end

      // R4: inputs move, select does not; output holds 1
      apply(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
      repeat (2) @(negedge clk);
      chk("R4 hold", comp, 1'b1);

      // R6: gate off, then retained bit returns at once
      en = 1'b0; #1;
      chk("R6 gated", comp, 1'b0);
      @(negedge clk); en = 1'b1; #1;
      chk("R6 restore", comp, 1'b1);

      // R5: rising select with voice 0; latency SYNC+1 edges
      @(negedge clk);
      sel = 1'b1; voice = 1'b0; ctl = 1'b0;
      repeat (SYNC) @(posedge clk);
      @(negedge clk);
      chk("R5 before capture", comp, 1'b1);
      @(posedge clk); @(negedge clk);
      chk("R5 at capture", comp, 1'b0);
      repeat (HALF) @(negedge clk);

      // R8: interleaved stream order voice then order-wire
      vb = 8'b1011_0010; ob = 8'b0110_1100; got = '0; want = '0;
      for (int i = 0; i < 8; i++) begin
         want[15-2*i] = vb[7-i];
         want[14-2*i] = ob[7-i];
      end
      apply(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      for (int i = 0; i < 8; i++) begin
         apply(1'b1, vb[7-i], 1'b0, 1'b0, 1'b1);
         got[15-2*i] = comp;
         apply(1'b0, 1'b0, 1'b0, ob[7-i], 1'b1);
         got[14-2*i] = comp;
      end
      nvec++;
      if (got !== want) begin
         nmiss++;
         $display("FAIL R8 stream actual=%b expected=%b", got, want);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmiss);
      $finish;
   end
endmodule